// File: doc/BRIEF.md
# Parallel-to-Serial Change-Triggered Transmitter

This block takes a group of parallel input pins, registers them on every system clock edge, and sends a chosen slice of that value out as a serial frame with a clock line, a data line and an active-low frame-enable line. The frame source is either the registered pins or an alternate word that the host writes. The width of the frame can be set from 4 to 16 bits, and the frame is sent most significant bit first.

When the block drives the serial clock itself, it decides on its own when each frame starts. There are four ways: frames can run back to back, start when the data changes, start on a rising edge of a hardware trigger, or start only when a trigger and a change occur together. A register holds the last frame sent. It is the reference for detecting a change, and it is also visible on an output.

When another device drives the serial clock, the block shifts its frame only under that external clock. In this role it also raises a chaining request when the data differs from the last frame, or when the hardware trigger is high, each subject to its own enable. The alternate-word write port is a valid/ready interface. Ready is low while a frame is being shifted, so the host must hold valid until ready returns. A write is taken on a clock edge where valid and ready are both high. Inside one frame, back-pressure lasts at most the frame's length.

Top module: `chg_ser_tx`

## Requirements
- R1: cfg_mode selects how frames start: 0 runs frames continuously, 1 starts on a change, 2 starts on a trigger, 3 needs both a trigger and a change. In mode 0, cs_n_o stays high for at least 2*HALF clock cycles between frames.
- R2: In mode 1, a frame starts when the selected source, masked to the frame width, differs from last_frame_o. No frame starts while the two are equal.
- R3: Only the low N bits take part in the compare. A change in bits at or above N starts no frame. A sent frame holds only the low N bits, with zeros above them in last_frame_o.
- R4: N is cfg_width clamped to the range 4..16. Each frame gives exactly N rising edges on sck_o.
- R5: cs_n_o stays low for the whole frame. sck_o is low whenever cs_n_o is high. Bits leave MSB first. sout_o changes only after a falling edge of sck_o and stays stable while sck_o is high.
- R6: cfg_src_alt=1 selects the alternate word as the source. cfg_src_alt=0 selects pin_in, which is registered on every clock edge. Pin changes have no effect while the alternate word is selected.
- R7: In mode 2, each rising edge of trig_in gives exactly one frame. A held level gives only one frame. An edge that arrives during a frame is latched and served after that frame.
- R8: In mode 3, a trigger that finds no change is discarded, and a change with no trigger starts nothing. A trigger together with a change starts one frame.
- R9: After reset: cs_n_o=1, sck_o=0, last_frame_o=0, chain_req_o=0 and alt_ready=1. Because last_frame_o starts at 0, the first nonzero sample counts as a change.
- R10: alt_ready is low while a frame is active. A write is accepted only when alt_valid and alt_ready are both high.
- R11: With cfg_slave=1, cs_n_o stays high and sck_o stays low. The frame is loaded on a falling edge of cs_n_i and shifted MSB first on falling edges of sck_i. last_frame_o takes the frame when cs_n_i rises.
- R12: chain_req_o goes high, one clock after its cause, when cfg_slave=1 and either (cfg_cmp_en=1 and the masked source differs from last_frame_o) or (cfg_trg_en=1 and trig_in is high). It is always 0 when cfg_slave=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | MAX_W | Parallel input pins |
| alt_valid | input | 1 | Alternate word write valid |
| alt_data | input | MAX_W | Alternate word write data |
| alt_ready | output | 1 | Alternate word write ready |
| trig_in | input | 1 | Hardware trigger |
| cfg_width | input | WW | Frame width, clamped to 4..MAX_W |
| cfg_src_alt | input | 1 | 1 selects the alternate word, 0 selects the pins |
| cfg_mode | input | 2 | Frame start mode |
| cfg_cmp_en | input | 1 | Chaining request on data change (external-clock role) |
| cfg_trg_en | input | 1 | Chaining request on trigger (external-clock role) |
| cfg_slave | input | 1 | 1 selects the external-clock role |
| sck_i | input | 1 | External serial clock |
| cs_n_i | input | 1 | External frame enable, active low |
| sck_o | output | 1 | Serial clock driven by the block |
| sout_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Frame enable driven by the block, active low |
| chain_req_o | output | 1 | Chaining request |
| last_frame_o | output | MAX_W | Last frame sent |

## Verification
The bench builds the block with MAX_W=16 and HALF=2. A full 16-bit frame then takes only 64 cycles, so the frame-width table, all four start modes, latched triggers and continuous runs fit into a few thousand cycles. With MAX_W at 16, both the lower clamp (a requested width of 2) and the full width can be reached. The short half period also makes the inter-frame gap of four cycles easy to measure exactly.

// File: rtl/chg_ser_tx_pkg.sv
package chg_ser_tx_pkg;
  typedef enum logic [1:0] {
    INIT_CONT     = 2'd0,
    INIT_CHANGE   = 2'd1,
    INIT_TRIG     = 2'd2,
    INIT_TRIG_CHG = 2'd3
  } init_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/chg_ser_tx_src.sv
module chg_ser_tx_src #(
  parameter int MAX_W = 16,
  parameter int MIN_W = 4,
  parameter int WW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_W-1:0] pin_in,
  input  logic             alt_we,
  input  logic [MAX_W-1:0] alt_wdata,
  input  logic             src_alt,
  input  logic [WW-1:0]    width,
  input  logic             cmp_load,
  input  logic [MAX_W-1:0] cmp_data,
  output logic [MAX_W-1:0] src_data,
  output logic             differs,
  output logic [WW-1:0]    eff_w,
  output logic [MAX_W-1:0] cmp_q
);
  localparam logic [WW-1:0] LO_W = WW'(MIN_W);
  localparam logic [WW-1:0] HI_W = WW'(MAX_W);

  logic [MAX_W-1:0] pin_q, alt_q, sel, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      alt_q <= '0;
      cmp_q <= '0;
    end else begin
      pin_q <= pin_in;
      if (alt_we)   alt_q <= alt_wdata;
      if (cmp_load) cmp_q <= cmp_data;
    end
  end

  always_comb begin
    if (width < LO_W)      eff_w = LO_W;
    else if (width > HI_W) eff_w = HI_W;
    else                   eff_w = width;
    mask     = {MAX_W{1'b1}} >> (HI_W - eff_w);
    sel      = src_alt ? alt_q : pin_q;
    src_data = sel & mask;
    differs  = |((sel ^ cmp_q) & mask);
  end
endmodule

// File: rtl/chg_ser_tx_trig.sv
module chg_ser_tx_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic clear,
  output logic pending,
  output logic level
);
  logic trig_d1, trig_d2, rise;

  assign rise  = trig_d1 & ~trig_d2;
  assign level = trig_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_d1 <= 1'b0;
      trig_d2 <= 1'b0;
      pending <= 1'b0;
    end else begin
      trig_d1 <= trig_in;
      trig_d2 <= trig_d1;
      if (rise)       pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/chg_ser_tx_master.sv
module chg_ser_tx_master
  import chg_ser_tx_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int HALF  = 2,
  parameter int WW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [MAX_W-1:0] load_data,
  input  logic [WW-1:0]    eff_w,
  output logic             sck,
  output logic             sout,
  output logic             cs_n,
  output logic             idle,
  output logic             done,
  output logic [MAX_W-1:0] frame
);
  localparam int DW = $clog2(2 * HALF + 1);
  localparam logic [DW-1:0] HALF_END = DW'(HALF - 1);
  localparam logic [DW-1:0] GAP_END  = DW'(2 * HALF - 1);
  localparam logic [WW-1:0] FULL_W   = WW'(MAX_W);

  eng_state_e       state;
  logic [DW-1:0]    div_cnt;
  logic [WW-1:0]    bits_left;
  logic [MAX_W-1:0] shreg;

  assign sout = shreg[MAX_W-1];
  assign idle = (state == ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      div_cnt   <= '0;
      bits_left <= '0;
      shreg     <= '0;
      frame     <= '0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state   <= ENG_IDLE;
        div_cnt <= '0;
        sck     <= 1'b0;
        cs_n    <= 1'b1;
      end else begin
        case (state)
          ENG_IDLE: begin
            if (start) begin
              shreg     <= load_data << (FULL_W - eff_w);
              frame     <= load_data;
              bits_left <= eff_w;
              div_cnt   <= '0;
              sck       <= 1'b0;
              cs_n      <= 1'b0;
              state     <= ENG_SHIFT;
            end
          end
          ENG_SHIFT: begin
            if (div_cnt == HALF_END) begin
              div_cnt <= '0;
              sck     <= ~sck;
              if (sck) begin
                if (bits_left == WW'(1)) begin
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
                  state <= ENG_GAP;
                end else begin
                  bits_left <= bits_left - WW'(1);
                  shreg     <= shreg << 1;
                end
              end
            end else begin
              div_cnt <= div_cnt + DW'(1);
            end
          end
          default: begin
            if (div_cnt == GAP_END) begin
              div_cnt <= '0;
              state   <= ENG_IDLE;
            end else begin
              div_cnt <= div_cnt + DW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/chg_ser_tx_slave.sv
module chg_ser_tx_slave #(
  parameter int MAX_W = 16,
  parameter int WW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic [MAX_W-1:0] load_data,
  input  logic [WW-1:0]    eff_w,
  output logic             sout,
  output logic             active,
  output logic             done,
  output logic [MAX_W-1:0] frame
);
  localparam logic [WW-1:0] FULL_W = WW'(MAX_W);

  logic             sck_m, sck_s, sck_p;
  logic             cs_m, cs_s, cs_p;
  logic [MAX_W-1:0] shreg;
  logic             cs_fall, cs_rise, sck_fall;

  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;
  assign sck_fall = ~sck_s & sck_p;
  assign sout     = shreg[MAX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 1'b0;
      sck_s  <= 1'b0;
      sck_p  <= 1'b0;
      cs_m   <= 1'b1;
      cs_s   <= 1'b1;
      cs_p   <= 1'b1;
      shreg  <= '0;
      frame  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      sck_m <= sck_i;
      sck_s <= sck_m;
      sck_p <= sck_s;
      cs_m  <= cs_n_i;
      cs_s  <= cs_m;
      cs_p  <= cs_s;
      done  <= 1'b0;
      if (!enable) begin
        active <= 1'b0;
      end else if (cs_fall) begin
        shreg  <= load_data << (FULL_W - eff_w);
        frame  <= load_data;
        active <= 1'b1;
      end else if (active && cs_rise) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else if (active && sck_fall) begin
        shreg <= shreg << 1;
      end
    end
  end
endmodule

// File: rtl/chg_ser_tx.sv
module chg_ser_tx
  import chg_ser_tx_pkg::*;
#(
  parameter int  MAX_W = 16,
  parameter int  MIN_W = 4,
  parameter int  HALF  = 2,
  localparam int WW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_W-1:0] pin_in,
  input  logic             alt_valid,
  input  logic [MAX_W-1:0] alt_data,
  output logic             alt_ready,
  input  logic             trig_in,
  input  logic [WW-1:0]    cfg_width,
  input  logic             cfg_src_alt,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_cmp_en,
  input  logic             cfg_trg_en,
  input  logic             cfg_slave,
  input  logic             sck_i,
  input  logic             cs_n_i,
  output logic             sck_o,
  output logic             sout_o,
  output logic             cs_n_o,
  output logic             chain_req_o,
  output logic [MAX_W-1:0] last_frame_o
);
  init_mode_e       mode;
  logic [MAX_W-1:0] src_data, m_frame, s_frame, cmp_data;
  logic [WW-1:0]    eff_w;
  logic             differs, pending, trig_lvl, start;
  logic             m_idle, m_done, m_sout;
  logic             s_sout, s_active, s_done, cmp_load, chain_q;

  assign mode = init_mode_e'(cfg_mode);

  chg_ser_tx_src #(.MAX_W(MAX_W), .MIN_W(MIN_W), .WW(WW)) u_src (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .alt_we(alt_valid & alt_ready), .alt_wdata(alt_data),
    .src_alt(cfg_src_alt), .width(cfg_width),
    .cmp_load(cmp_load), .cmp_data(cmp_data),
    .src_data(src_data), .differs(differs), .eff_w(eff_w), .cmp_q(last_frame_o)
  );

  chg_ser_tx_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .clear(m_idle),
    .pending(pending), .level(trig_lvl)
  );

  always_comb begin
    case (mode)
      INIT_CONT:   start = 1'b1;
      INIT_CHANGE: start = differs;
      INIT_TRIG:   start = pending;
      default:     start = pending & differs;
    endcase
  end

  chg_ser_tx_master #(.MAX_W(MAX_W), .HALF(HALF), .WW(WW)) u_master (
    .clk(clk), .rst_n(rst_n), .enable(~cfg_slave), .start(start),
    .load_data(src_data), .eff_w(eff_w),
    .sck(sck_o), .sout(m_sout), .cs_n(cs_n_o),
    .idle(m_idle), .done(m_done), .frame(m_frame)
  );

  chg_ser_tx_slave #(.MAX_W(MAX_W), .WW(WW)) u_slave (
    .clk(clk), .rst_n(rst_n), .enable(cfg_slave),
    .sck_i(sck_i), .cs_n_i(cs_n_i), .load_data(src_data), .eff_w(eff_w),
    .sout(s_sout), .active(s_active), .done(s_done), .frame(s_frame)
  );

  assign cmp_load  = m_done | s_done;
  assign cmp_data  = m_done ? m_frame : s_frame;
  assign sout_o    = cfg_slave ? s_sout : m_sout;
  assign alt_ready = cs_n_o & ~s_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 1'b0;
    else        chain_q <= cfg_slave & ((cfg_cmp_en & differs) | (cfg_trg_en & trig_lvl));
  end
  assign chain_req_o = chain_q;
endmodule

// File: rtl/chg_ser_tx_chk.sv
module chg_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_slave,
  input logic sck_o,
  input logic sout_o,
  input logic cs_n_o,
  input logic alt_ready,
  input logic chain_req_o
);
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  // R5
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && !$past(cfg_slave) && sck_o && $past(sck_o)) |-> $stable(sout_o));

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !alt_ready);

  // R11
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && $past(cfg_slave)) |-> (cs_n_o && !sck_o));

  // R12
  chain_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req_o |-> $past(cfg_slave));
endmodule

bind chg_ser_tx chg_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .sck_o(sck_o),
  .sout_o(sout_o), .cs_n_o(cs_n_o), .alt_ready(alt_ready), .chain_req_o(chain_req_o)
);

// File: tb/chg_ser_tx_bench.sv
module chg_ser_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  typedef struct packed {
    logic [4:0]  w;
    logic [15:0] pins;
    logic        fire;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{5'd8,  16'h00A5, 1'b1, 16'h00A5},
    '{5'd8,  16'h00A5, 1'b0, 16'h0000},
    '{5'd8,  16'h7FA5, 1'b0, 16'h0000},
    '{5'd8,  16'h7F5A, 1'b1, 16'h005A},
    '{5'd4,  16'h7F5A, 1'b0, 16'h0000},
    '{5'd4,  16'h0003, 1'b1, 16'h0003},
    '{5'd16, 16'h0003, 1'b0, 16'h0000},
    '{5'd16, 16'hC003, 1'b1, 16'hC003},
    '{5'd12, 16'h0ABC, 1'b1, 16'h0ABC},
    '{5'd2,  16'h0ABD, 1'b1, 16'h000D}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] pin_in = 0, alt_data = 0;
  logic alt_valid = 0, trig_in = 0, cfg_src_alt = 0, cfg_cmp_en = 0, cfg_trg_en = 0;
  logic cfg_slave = 0, sck_i = 0, cs_n_i = 1;
  logic [4:0] cfg_width = 8;
  logic [1:0] cfg_mode = 2'd1;
  logic alt_ready, sck_o, sout_o, cs_n_o, chain_req_o;
  logic [15:0] last_frame_o;

  int total = 0, bad = 0;
  int mon_frames = 0, mon_bits = 0, nb = 0, cyc = 0, gap_start = 0, min_gap = 1000000;
  logic [15:0] mon_last = 0, shv = 0;
  logic prev_sck = 0, prev_cs = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chg_ser_tx #(.MAX_W(16), .MIN_W(4), .HALF(HALF)) u_chg_ser_tx (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .alt_valid(alt_valid),
    .alt_data(alt_data), .alt_ready(alt_ready), .trig_in(trig_in),
    .cfg_width(cfg_width), .cfg_src_alt(cfg_src_alt), .cfg_mode(cfg_mode),
    .cfg_cmp_en(cfg_cmp_en), .cfg_trg_en(cfg_trg_en), .cfg_slave(cfg_slave),
    .sck_i(sck_i), .cs_n_i(cs_n_i), .sck_o(sck_o), .sout_o(sout_o),
    .cs_n_o(cs_n_o), .chain_req_o(chain_req_o), .last_frame_o(last_frame_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prev_cs && !cs_n_o) begin
      shv = 0;
      nb = 0;
      if (mon_frames > 0 && (cyc - gap_start) < min_gap) min_gap = cyc - gap_start;
    end
    if (!cs_n_o && sck_o && !prev_sck) begin
      shv = {shv[14:0], sout_o};
      nb = nb + 1;
    end
    if (!prev_cs && cs_n_o) begin
      mon_frames = mon_frames + 1;
      mon_last = shv;
      mon_bits = nb;
      gap_start = cyc;
    end
    prev_sck = sck_o;
    prev_cs = cs_n_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig;
    @(negedge clk) trig_in = 1;
    wait_n(3);
    trig_in = 0;
  endtask

  task automatic slave_frame(input int n, output logic [15:0] v);
    v = 0;
    @(negedge clk) cs_n_i = 0;
    wait_n(8);
    for (int i = 0; i < n; i++) begin
      v = {v[14:0], sout_o};
      sck_i = 1;
      wait_n(8);
      sck_i = 0;
      wait_n(8);
    end
    cs_n_i = 1;
    wait_n(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0, ew;
    logic [15:0] sv;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R9 reset state
    chk(cs_n_o == 1, "R9 cs_n_o", cs_n_o, 1);
    chk(sck_o == 0, "R9 sck_o", sck_o, 0);
    chk(last_frame_o == 0, "R9 last_frame", last_frame_o, 0);
    chk(chain_req_o == 0 && alt_ready == 1, "R9 chain/ready", {chain_req_o, alt_ready}, 1);
    f0 = mon_frames;
    wait_n(50);
    chk(mon_frames == f0, "R9 zero data no frame", mon_frames - f0, 0);

    // R2 R3 R4 R5 table in change mode
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cfg_width = VEC[k].w;
      pin_in = VEC[k].pins;
      f0 = mon_frames;
      wait_n(120);
      ew = (VEC[k].w < 4) ? 4 : ((VEC[k].w > 16) ? 16 : int'(VEC[k].w));
      chk((mon_frames - f0) == int'(VEC[k].fire), "R2/R3 frame count", mon_frames - f0, VEC[k].fire);
      if (VEC[k].fire) begin
        chk(mon_last == VEC[k].exp, "R5 serial value MSB first", mon_last, VEC[k].exp);
        chk(mon_bits == ew, "R4 bit count", mon_bits, ew);
        chk(last_frame_o == VEC[k].exp, "R3 last_frame masked", last_frame_o, VEC[k].exp);
      end
    end

    // R6 R10 alternate source
    @(negedge clk) alt_valid = 1; alt_data = 16'h003C;
    @(negedge clk) alt_valid = 0;
    cfg_src_alt = 1;
    cfg_width = 8;
    f0 = mon_frames;
    for (int i = 0; i < 50 && cs_n_o; i++) @(negedge clk);
    chk(cs_n_o == 0 && alt_ready == 0, "R10 ready low in frame", alt_ready, 0);
    wait_n(120);
    chk(mon_frames - f0 == 1 && mon_last == 16'h003C, "R6 alt source frame", mon_last, 16'h3C);
    @(negedge clk) pin_in = 16'h1234;
    f0 = mon_frames;
    wait_n(120);
    chk(mon_frames == f0, "R6 pins ignored on alt", mon_frames - f0, 0);

    // R7 trigger mode
    @(negedge clk) cfg_mode = 2'd2; cfg_src_alt = 0; pin_in = 16'h0011;
    f0 = mon_frames;
    wait_n(60);
    chk(mon_frames == f0, "R7 no trigger no frame", mon_frames - f0, 0);
    pulse_trig();
    wait_n(120);
    chk(mon_frames - f0 == 1 && mon_last == 16'h0011, "R7 one frame per edge", mon_frames - f0, 1);
    f0 = mon_frames;
    @(negedge clk) trig_in = 1;
    wait_n(250);
    @(negedge clk) trig_in = 0;
    chk(mon_frames - f0 == 1, "R7 held level one frame", mon_frames - f0, 1);
    wait_n(10);
    f0 = mon_frames;
    pulse_trig();
    for (int i = 0; i < 50 && cs_n_o; i++) @(negedge clk);
    wait_n(3);
    pulse_trig();
    wait_n(200);
    chk(mon_frames - f0 == 2, "R7 latched trigger served", mon_frames - f0, 2);

    // R8 trigger plus change
    @(negedge clk) cfg_mode = 2'd3;
    f0 = mon_frames;
    pulse_trig();
    wait_n(120);
    chk(mon_frames == f0, "R8 trigger without change", mon_frames - f0, 0);
    @(negedge clk) pin_in = 16'h0022;
    wait_n(120);
    chk(mon_frames == f0, "R8 change without trigger", mon_frames - f0, 0);
    pulse_trig();
    wait_n(120);
    chk(mon_frames - f0 == 1 && mon_last == 16'h0022, "R8 trigger with change", mon_last, 16'h22);

    // R1 continuous
    @(negedge clk) cfg_mode = 2'd0;
    min_gap = 1000000;
    f0 = mon_frames;
    wait_n(400);
    chk(mon_frames - f0 >= 5, "R1 continuous frames", mon_frames - f0, 5);
    chk(min_gap >= 2 * HALF, "R1 idle gap", min_gap, 2 * HALF);
    chk(mon_last == 16'h0022 && mon_bits == 8, "R1 continuous value", mon_last, 16'h22);

    // R11 slave role
    @(negedge clk) cfg_slave = 1;
    wait_n(60);
    f0 = mon_frames;
    @(negedge clk) pin_in = 16'h00C5;
    wait_n(100);
    chk(mon_frames == f0 && cs_n_o == 1, "R11 no self start", mon_frames - f0, 0);
    slave_frame(8, sv);
    chk(sv == 16'h00C5, "R11 slave shifted value", sv, 16'hC5);
    chk(last_frame_o == 16'h00C5, "R11 slave last frame", last_frame_o, 16'hC5);

    // R12 chaining request
    @(negedge clk) cfg_cmp_en = 1;
    wait_n(4);
    chk(chain_req_o == 0, "R12 equal data no request", chain_req_o, 0);
    @(negedge clk) pin_in = 16'h00C6;
    wait_n(4);
    chk(chain_req_o == 1, "R12 change request", chain_req_o, 1);
    @(negedge clk) cfg_cmp_en = 0;
    wait_n(4);
    chk(chain_req_o == 0, "R12 compare disabled", chain_req_o, 0);
    @(negedge clk) cfg_trg_en = 1; trig_in = 1;
    wait_n(4);
    chk(chain_req_o == 1, "R12 trigger request", chain_req_o, 1);
    @(negedge clk) trig_in = 0;
    wait_n(4);
    chk(chain_req_o == 0, "R12 trigger released", chain_req_o, 0);
    @(negedge clk) cfg_mode = 2'd2; cfg_cmp_en = 1; trig_in = 1; cfg_slave = 0;
    wait_n(4);
    @(negedge clk) trig_in = 0;
    wait_n(100);
    chk(chain_req_o == 0, "R12 no request in master role", chain_req_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule